// File: doc/BRIEF.md
# LIN Host Header Generator

This block produces the header portion of a LIN frame for a node acting as bus host. A single-cycle start request, taken while the block is idle, launches a fixed five-part sequence on one transmit line: a dominant break, a recessive gap, the sync character, a second recessive gap, and the protected identifier character. The break length comes from a 2-bit select. A 2-bit delay select sets both gaps. The identifier comes from a 6-bit input, and the block adds the two parity bits to it.

Timing comes only from an external one-cycle `bit_tick` strobe that marks the end of each bit period. The block does not divide the baud rate itself. The select inputs and the identifier are captured when a start is accepted. While a header is running, any start or change on those inputs has no effect. `busy` covers the whole header, and `done` pulses once when the last stop bit has been sent.

Top module: `lin_hdr_gen`

## Requirements
- R1: Out of reset and whenever idle, `tx` is 1 (recessive), `busy` is 0 and `done` is 0.
- R2: A `start` sampled high at a clock edge while idle makes `busy` 1 and `tx` 0 from that edge onward. The break begins there.
- R3: The break keeps `tx` at 0 for a number of `bit_tick` strobes set by `brk_sel`: code 0 gives 13, code 1 gives 17, code 2 gives 21, code 3 gives 26.
- R4: After the break, `tx` stays 1 for a number of strobes set by `dly_sel`: code 0 gives 1, code 1 gives 4, code 2 gives 8, code 3 gives 14.
- R5: Between the sync and identifier characters, `tx` stays 1 for 1 strobe when `dly_sel` is 0 and for 4 strobes for any other code.
- R6: The sync character is sent over 10 strobes. The order is a start bit of 0, then the byte 0x55 least significant bit first (1,0,1,0,1,0,1,0), then a stop bit of 1.
- R7: The identifier character is sent over 10 strobes in the same start/LSB-first/stop form. Its byte has `frame_id[5:0]` in bits 5:0, bit 6 = id0^id1^id2^id4, and bit 7 = NOT(id1^id3^id4^id5).
- R8: At the clock edge that takes the strobe ending the identifier stop bit, `busy` falls and `done` goes to 1 for exactly one cycle. After that edge `tx` is 1.
- R9: A `start`, or a change of `brk_sel`, `dly_sel` or `frame_id`, while `busy` is 1 does not change the header being sent.
- R10: While busy, `tx` changes only at clock edges where `bit_tick` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_tick | input | 1 | One-cycle strobe at the end of each bit period |
| start | input | 1 | Header launch request |
| brk_sel | input | 2 | Break length code |
| dly_sel | input | 2 | Inter-field gap code |
| frame_id | input | 6 | Frame identifier without parity |
| tx | output | 1 | Serial line, 0 dominant, 1 recessive |
| busy | output | 1 | Header in progress |
| done | output | 1 | One-cycle pulse at header completion |

## Verification
Almost every internal fault in this block appears on `tx` within a few bit periods. A phase counter that is wrong by one shifts every later field by a full bit. The bench checks this by recording `tx` at each strobe and comparing the stream, field by field, with a sequence built arithmetically from the codes. Header length, parity or sync errors therefore appear at the first bit that differs, and a stuck phase shows up as a missing `done` that trips the wait limit. The bench covers every break/delay pairing and all 64 identifiers, and sends restart attempts part-way through headers.

// File: rtl/lin_hdr_pkg.sv
package lin_hdr_pkg;
   typedef enum logic [2:0] {
      PH_IDLE = 3'd0,
      PH_BRK  = 3'd1,
      PH_GAP1 = 3'd2,
      PH_SYNC = 3'd3,
      PH_GAP2 = 3'd4,
      PH_PID  = 3'd5
   } phase_t;

   localparam int unsigned SYNC_BYTE = 8'h55;
   localparam int unsigned BYTE_W    = 8;
   localparam int unsigned CHAR_W    = BYTE_W + 2;

   function automatic int unsigned max_of4(int unsigned a, int unsigned b,
                                           int unsigned c, int unsigned d);
      int unsigned m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction
endpackage

// File: rtl/lin_pid_calc.sv
module lin_pid_calc #(
   parameter int unsigned ID_W = 6
) (
   input  logic [ID_W-1:0] id_i,
   output logic [7:0]      pid_o
);
   generate
      if (ID_W != 6) begin : g_bad_width
         $error("lin_pid_calc: identifier must be 6 bits");
      end
   endgenerate

   logic par_lo, par_hi;
   always_comb begin
      par_lo = id_i[0] ^ id_i[1] ^ id_i[2] ^ id_i[4];
      par_hi = ~(id_i[1] ^ id_i[3] ^ id_i[4] ^ id_i[5]);
      pid_o  = {par_hi, par_lo, id_i[5:0]};
   end
endmodule

// File: rtl/lin_hdr_lengths.sv
module lin_hdr_lengths #(
   parameter int unsigned CW       = 5,
   parameter int unsigned BRK_T0   = 13,
   parameter int unsigned BRK_T1   = 17,
   parameter int unsigned BRK_T2   = 21,
   parameter int unsigned BRK_T3   = 26,
   parameter int unsigned GAPA_T0  = 1,
   parameter int unsigned GAPA_T1  = 4,
   parameter int unsigned GAPA_T2  = 8,
   parameter int unsigned GAPA_T3  = 14,
   parameter int unsigned GAPB_MIN = 1,
   parameter int unsigned GAPB_STD = 4
) (
   input  logic [1:0]    brk_code_i,
   input  logic [1:0]    dly_code_i,
   output logic [CW-1:0] brk_len_o,
   output logic [CW-1:0] gapa_len_o,
   output logic [CW-1:0] gapb_len_o
);
   localparam int unsigned BRK_TAB  [4] = '{BRK_T0, BRK_T1, BRK_T2, BRK_T3};
   localparam int unsigned GAPA_TAB [4] = '{GAPA_T0, GAPA_T1, GAPA_T2, GAPA_T3};

   genvar k;
   generate
      for (k = 0; k < 4; k++) begin : g_chk
         if (BRK_TAB[k] < 1 || BRK_TAB[k] >= (1 << CW)) begin : g_bad_brk
            $error("lin_hdr_lengths: break length out of counter range");
         end
         if (GAPA_TAB[k] < 1 || GAPA_TAB[k] >= (1 << CW)) begin : g_bad_gap
            $error("lin_hdr_lengths: first gap out of counter range");
         end
      end
      if (GAPB_MIN < 1 || GAPB_STD < 1 ||
          GAPB_MIN >= (1 << CW) || GAPB_STD >= (1 << CW)) begin : g_bad_gapb
         $error("lin_hdr_lengths: second gap out of counter range");
      end
   endgenerate

   always_comb begin
      brk_len_o  = CW'(BRK_TAB[brk_code_i]);
      gapa_len_o = CW'(GAPA_TAB[dly_code_i]);
      gapb_len_o = (dly_code_i == 2'd0) ? CW'(GAPB_MIN) : CW'(GAPB_STD);
   end
endmodule

// File: rtl/lin_char_ser.sv
module lin_char_ser #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic              shift_i,
   input  logic [DATA_W-1:0] data_i,
   output logic              bit_o
);
   localparam int unsigned FRAME_W = DATA_W + 2;

   generate
      if (DATA_W < 1) begin : g_bad_data
         $error("lin_char_ser: data width must be positive");
      end
   endgenerate

   logic [FRAME_W-1:0] sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q <= '1;
      end else if (load_i) begin
         sh_q <= {1'b1, data_i, 1'b0};
      end else if (shift_i) begin
         sh_q <= {1'b1, sh_q[FRAME_W-1:1]};
      end
   end

   assign bit_o = sh_q[0];
endmodule

// File: rtl/lin_hdr_ctrl.sv
module lin_hdr_ctrl
   import lin_hdr_pkg::*;
#(
   parameter int unsigned CW = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bit_tick,
   input  logic          start,
   input  logic [CW-1:0] brk_len_i,
   input  logic [CW-1:0] gapa_len_i,
   input  logic [CW-1:0] gapb_len_i,
   output phase_t        phase_o,
   output logic          accept_o,
   output logic          ld_sync_o,
   output logic          ld_pid_o,
   output logic          shift_o,
   output logic          done_o
);
   generate
      if (CW < $clog2(CHAR_W + 1)) begin : g_bad_cw
         $error("lin_hdr_ctrl: counter too narrow for a character");
      end
   endgenerate

   phase_t        ph_q, ph_nx;
   logic [CW-1:0] cnt_q;
   logic [CW-1:0] cur_len;
   logic          last_bit;
   logic          char_ph;
   logic          done_q;

   always_comb begin
      unique case (ph_q)
         PH_BRK:          cur_len = brk_len_i;
         PH_GAP1:         cur_len = gapa_len_i;
         PH_GAP2:         cur_len = gapb_len_i;
         PH_SYNC, PH_PID: cur_len = CW'(CHAR_W);
         default:         cur_len = CW'(1);
      endcase
   end

   always_comb begin
      unique case (ph_q)
         PH_BRK:  ph_nx = PH_GAP1;
         PH_GAP1: ph_nx = PH_SYNC;
         PH_SYNC: ph_nx = PH_GAP2;
         PH_GAP2: ph_nx = PH_PID;
         default: ph_nx = PH_IDLE;
      endcase
   end

   assign last_bit = (cnt_q == cur_len - CW'(1));
   assign char_ph  = (ph_q == PH_SYNC) || (ph_q == PH_PID);
   assign accept_o = start && (ph_q == PH_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q   <= PH_IDLE;
         cnt_q  <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (ph_q == PH_IDLE) begin
            cnt_q <= '0;
            if (start) ph_q <= PH_BRK;
         end else if (bit_tick) begin
            if (last_bit) begin
               cnt_q <= '0;
               ph_q  <= ph_nx;
               if (ph_q == PH_PID) done_q <= 1'b1;
            end else begin
               cnt_q <= cnt_q + CW'(1);
            end
         end
      end
   end

   assign ld_sync_o = bit_tick && last_bit && (ph_q == PH_GAP1);
   assign ld_pid_o  = bit_tick && last_bit && (ph_q == PH_GAP2);
   assign shift_o   = bit_tick && !last_bit && char_ph;
   assign phase_o   = ph_q;
   assign done_o    = done_q;
endmodule

// File: rtl/lin_hdr_gen.sv
module lin_hdr_gen
   import lin_hdr_pkg::*;
#(
   parameter int unsigned ID_W     = 6,
   parameter int unsigned BRK_T0   = 13,
   parameter int unsigned BRK_T1   = 17,
   parameter int unsigned BRK_T2   = 21,
   parameter int unsigned BRK_T3   = 26,
   parameter int unsigned GAPA_T0  = 1,
   parameter int unsigned GAPA_T1  = 4,
   parameter int unsigned GAPA_T2  = 8,
   parameter int unsigned GAPA_T3  = 14,
   parameter int unsigned GAPB_MIN = 1,
   parameter int unsigned GAPB_STD = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            bit_tick,
   input  logic            start,
   input  logic [1:0]      brk_sel,
   input  logic [1:0]      dly_sel,
   input  logic [ID_W-1:0] frame_id,
   output logic            tx,
   output logic            busy,
   output logic            done
);
   localparam int unsigned MAX_FIELD = max_of4(
      max_of4(BRK_T0, BRK_T1, BRK_T2, BRK_T3),
      max_of4(GAPA_T0, GAPA_T1, GAPA_T2, GAPA_T3),
      max_of4(GAPB_MIN, GAPB_STD, CHAR_W, 1), 1);
   localparam int unsigned CW = $clog2(MAX_FIELD + 1);

   phase_t          phase;
   logic            accept, ld_sync, ld_pid, shift, ser_bit;
   logic [1:0]      brk_q, dly_q;
   logic [ID_W-1:0] id_q;
   logic [CW-1:0]   brk_len, gapa_len, gapb_len;
   logic [7:0]      pid_byte;
   logic [7:0]      ser_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         brk_q <= '0;
         dly_q <= '0;
         id_q  <= '0;
      end else if (accept) begin
         brk_q <= brk_sel;
         dly_q <= dly_sel;
         id_q  <= frame_id;
      end
   end

   lin_hdr_lengths #(
      .CW(CW), .BRK_T0(BRK_T0), .BRK_T1(BRK_T1), .BRK_T2(BRK_T2), .BRK_T3(BRK_T3),
      .GAPA_T0(GAPA_T0), .GAPA_T1(GAPA_T1), .GAPA_T2(GAPA_T2), .GAPA_T3(GAPA_T3),
      .GAPB_MIN(GAPB_MIN), .GAPB_STD(GAPB_STD)
   ) u_len (
      .brk_code_i (brk_q),
      .dly_code_i (dly_q),
      .brk_len_o  (brk_len),
      .gapa_len_o (gapa_len),
      .gapb_len_o (gapb_len)
   );

   lin_pid_calc #(.ID_W(ID_W)) u_pid (
      .id_i  (id_q),
      .pid_o (pid_byte)
   );

   lin_hdr_ctrl #(.CW(CW)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .bit_tick   (bit_tick),
      .start      (start),
      .brk_len_i  (brk_len),
      .gapa_len_i (gapa_len),
      .gapb_len_i (gapb_len),
      .phase_o    (phase),
      .accept_o   (accept),
      .ld_sync_o  (ld_sync),
      .ld_pid_o   (ld_pid),
      .shift_o    (shift),
      .done_o     (done)
   );

   assign ser_data = ld_pid ? pid_byte : 8'(SYNC_BYTE);

   lin_char_ser #(.DATA_W(BYTE_W)) u_ser (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (ld_sync || ld_pid),
      .shift_i (shift),
      .data_i  (ser_data),
      .bit_o   (ser_bit)
   );

   always_comb begin
      unique case (phase)
         PH_BRK:          tx = 1'b0;
         PH_SYNC, PH_PID: tx = ser_bit;
         default:         tx = 1'b1;
      endcase
   end

   assign busy = (phase != PH_IDLE);
endmodule

// File: rtl/lin_hdr_chk.sv
module lin_hdr_chk (
   input logic clk,
   input logic rst_n,
   input logic bit_tick,
   input logic start,
   input logic tx,
   input logic busy,
   input logic done
);
   localparam int unsigned MIN_TICKS = 35;
   localparam int unsigned MAX_TICKS = 64;

   logic [7:0] tick_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             tick_cnt <= '0;
      else if (!busy)         tick_cnt <= '0;
      else if (bit_tick)      tick_cnt <= tick_cnt + 8'd1;
   end

   assert_idle_recessive_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> tx);

   assert_break_begins_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> (!tx && $past(start)));

   assert_header_span_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (tick_cnt >= 8'(MIN_TICKS) && tick_cnt <= 8'(MAX_TICKS)));

   assert_done_ends_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy) && $past(bit_tick)));

   assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_restart_no_effect_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start && !bit_tick) |=> (busy && $stable(tx)));

   assert_tx_on_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && !$past(bit_tick)) |-> $stable(tx));
endmodule

bind lin_hdr_gen lin_hdr_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bit_tick (bit_tick),
   .start    (start),
   .tx       (tx),
   .busy     (busy),
   .done     (done)
);

// File: tb/sim_lin_hdr_gen.sv
module sim_lin_hdr_gen;
   localparam int CLK_PERIOD = 10;
   localparam int TICK_DIV   = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bit_tick = 1'b0;
   logic       start = 1'b0;
   logic [1:0] brk_sel = '0;
   logic [1:0] dly_sel = '0;
   logic [5:0] frame_id = '0;
   logic       tx, busy, done;

   int total = 0;
   int bad = 0;
   logic rec [0:127];
   int rec_n = 0;
   int done_cnt = 0;
   int glitch_cnt = 0;
   logic prev_tx = 1'b1;
   logic prev_busy = 1'b0;
   int div_cnt = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   lin_hdr_gen u0 (
      .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .start(start),
      .brk_sel(brk_sel), .dly_sel(dly_sel), .frame_id(frame_id),
      .tx(tx), .busy(busy), .done(done)
   );

   initial begin
      forever begin
         @(negedge clk);
         if (busy && prev_busy && (tx != prev_tx) && !bit_tick) glitch_cnt++;
         if (done) done_cnt++;
         prev_tx   = tx;
         prev_busy = busy;
         div_cnt   = (div_cnt + 1) % TICK_DIV;
         bit_tick  = (div_cnt == TICK_DIV - 1);
         if (bit_tick && busy && rec_n < 128) begin
            rec[rec_n] = tx;
            rec_n++;
         end
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int brk_ticks(input int code);
      return (code == 0) ? 13 : (code == 1) ? 17 : (code == 2) ? 21 : 26;
   endfunction

   function automatic int gapa_ticks(input int code);
      return (code == 0) ? 1 : (code == 1) ? 4 : (code == 2) ? 8 : 14;
   endfunction

   task automatic run_hdr(input int b, input int d, input int id, input bit disturb);
      logic exp [0:127];
      int n, bl, ga, gb, idx, mism, waited;
      logic [7:0] pid;
      bl = brk_ticks(b);
      ga = gapa_ticks(d);
      gb = (d == 0) ? 1 : 4;
      pid[5:0] = 6'(id);
      pid[6] = pid[0] ^ pid[1] ^ pid[2] ^ pid[4];
      pid[7] = ~(pid[1] ^ pid[3] ^ pid[4] ^ pid[5]);
      n = 0;
      for (int i = 0; i < bl; i++) begin exp[n] = 1'b0; n++; end
      for (int i = 0; i < ga; i++) begin exp[n] = 1'b1; n++; end
      exp[n] = 1'b0; n++;
      for (int i = 0; i < 8; i++) begin exp[n] = i[0] ? 1'b0 : 1'b1; n++; end
      exp[n] = 1'b1; n++;
      for (int i = 0; i < gb; i++) begin exp[n] = 1'b1; n++; end
      exp[n] = 1'b0; n++;
      for (int i = 0; i < 8; i++) begin exp[n] = pid[i]; n++; end
      exp[n] = 1'b1; n++;

      @(negedge clk);
      brk_sel = 2'(b); dly_sel = 2'(d); frame_id = 6'(id);
      rec_n = 0; done_cnt = 0; glitch_cnt = 0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(busy && !tx, "R2", {30'd0, busy, tx}, 2);
      if (disturb) begin
         repeat (20) @(negedge clk);
         start = 1'b1; brk_sel = ~brk_sel; dly_sel = ~dly_sel; frame_id = ~frame_id;
         @(negedge clk);
         start = 1'b0;
      end
      waited = 0;
      while (done_cnt == 0 && waited < 2000) begin
         @(negedge clk);
         waited++;
      end
      check(waited < 2000, "R8 timeout", waited, 0);
      repeat (3) @(negedge clk);
      check(done_cnt == 1, "R8 pulse", done_cnt, 1);
      check(!busy && tx, "R8 idle", {30'd0, busy, tx}, 1);
      check(rec_n == n, disturb ? "R9 length" : "R3 length", rec_n, n);
      mism = 0;
      for (int i = 0; i < bl; i++) if (rec[i] !== exp[i]) mism++;
      check(mism == 0, "R3 break", mism, 0);
      mism = 0;
      for (int i = bl; i < bl + ga; i++) if (rec[i] !== exp[i]) mism++;
      check(mism == 0, "R4 gap", mism, 0);
      mism = 0;
      for (int i = bl + ga; i < bl + ga + 10; i++) if (rec[i] !== exp[i]) mism++;
      check(mism == 0, "R6 sync", mism, 0);
      mism = 0;
      idx = bl + ga + 10;
      for (int i = idx; i < idx + gb; i++) if (rec[i] !== exp[i]) mism++;
      check(mism == 0, "R5 gap", mism, 0);
      mism = 0;
      idx = idx + gb;
      for (int i = idx; i < idx + 10 && i < 128; i++) if (rec[i] !== exp[i]) mism++;
      check(mism == 0, disturb ? "R9 pid" : "R7 pid", mism, 0);
      check(glitch_cnt == 0, "R10", glitch_cnt, 0);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check(tx && !busy && !done, "R1 reset", {29'd0, tx, busy, done}, 4);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      check(tx && !busy && !done, "R1 idle", {29'd0, tx, busy, done}, 4);
      for (int b = 0; b < 4; b++)
         for (int d = 0; d < 4; d++)
            run_hdr(b, d, (b * 16 + d * 5 + 3) % 64, 1'b0);
      for (int id = 0; id < 64; id++)
         run_hdr(id % 4, (id / 4) % 4, id, 1'b0);
      for (int b = 0; b < 4; b++)
         run_hdr(b, 3 - b, 17 * b + 9, 1'b1);
      repeat (10) @(negedge clk);
      check(tx && !busy, "R1 final", {30'd0, tx, busy}, 2);
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule